// File: doc/BRIEF.md
# UART Receive Line Status Logic

This block is the receive half of a 16550-style serial port, seen from the status side. A small oversampling sampler turns the serial line into characters. Each character has 8 data bits, sent least significant bit first, and one even-parity bit. Each finished character carries two tags: a parity-error tag and a framing-error tag. The character and its tags go into a receive FIFO together.

The host reads characters from the head of the FIFO. It also reads a 4-bit line status word. A parity or framing error is reported only when the tagged character becomes the FIFO head, not when the character arrives. If a character completes while the FIFO is full, the block reports an overrun and drops that character; the stored characters are kept unchanged.

When the stop position is sampled low, the sampler takes that low level as the start bit of the next character. It checks the level once more on the following clock and goes straight on to the data bits.

Top module: `uart_rx_line_status`

## Requirements
- R1: After a synchronous reset, `line_stat`, `ls_irq` and `rd_data` are all 0.
- R2: A frame on `rxd` is a low start bit, then 8 data bits least significant first, then a parity bit, then a high stop bit. Each bit lasts OVS clocks. Even parity is expected: the data bits and the parity bit together hold an even number of ones. A completed frame is stored in the FIFO with its data byte.
- R3: `line_stat[0]` (data ready) is 1 while at least one character is stored. It is 0 once the last character has been read out.
- R4: A pulse on `rd_en` while the FIFO is not empty removes the head character. Its byte appears on `rd_data` from the next cycle on, and characters leave in arrival order. A pulse on `rd_en` while the FIFO is empty does nothing: `rd_data` keeps its value.
- R5: `line_stat[1]` (overrun) sets when a character completes while the FIFO is full and no read happens in that cycle. That character is dropped and the stored characters are unchanged.
- R6: `line_stat[2]` (parity error) and `line_stat[3]` (framing error) take the tags of the character at the FIFO head. They are latched two cycles after the head changes. A tagged character that is not at the head does not set them.
- R7: Bits 1 to 3 of `line_stat` hold their value until a cycle with `lsr_rd` high, which clears them. A set event in that same cycle takes priority over the clear.
- R8: If `lsr_rd` and `rd_en` are both high in one cycle, `line_stat` in that cycle shows the flags of the old head. The flags of the new head appear one cycle after the clear.
- R9: A low stop bit sets the framing tag. The receiver then takes the low stop level as the start bit of the next character: it samples the level once more one clock later and, if it is still low, receives 8 data bits, parity and stop immediately after.
- R10: `ls_irq` is 1 exactly when any of `line_stat[3:1]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxd | input | 1 | Serial receive line, idle high |
| rd_en | input | 1 | Host read strobe: removes the FIFO head |
| lsr_rd | input | 1 | Host read strobe for the line status word |
| rd_data | output | 8 | Byte of the last character read out |
| line_stat | output | 4 | Line status: bit 0 data ready, bit 1 overrun, bit 2 parity error, bit 3 framing error |
| ls_irq | output | 1 | Line status interrupt request |

## Verification
The bench builds the block with OVS = 4 and a FIFO depth of 4. At these sizes a frame lasts 44 clocks, so the bench can send every one of the 256 byte values, with parity corrupted on every third value, and compute the expected status word from each byte. The small FIFO reaches the full state after four characters. That makes it practical to test the overrun drop and the head-only reporting of errors with characters queued behind the head. The same settings also cover the same-cycle read and pop, and the resynchronisation after a low stop bit, both with a following character and with an idle line.

// File: rtl/uart_rx_ls_pkg.sv
package uart_rx_ls_pkg;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned STAT_W = 4;

  // Status word bit positions, decoded by the host.
  localparam int unsigned ST_DR = 0;
  localparam int unsigned ST_OE = 1;
  localparam int unsigned ST_PE = 2;
  localparam int unsigned ST_FE = 3;

  typedef struct packed {
    logic              fe;
    logic              pe;
    logic [CHAR_W-1:0] data;
  } rx_char_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_RESYNC
  } samp_st_t;
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_ls_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     rxd,
  output logic     ch_valid,
  output rx_char_t ch
);
  localparam int unsigned CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int unsigned BW = $clog2(CHAR_W);

  samp_st_t          st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [CHAR_W-1:0] shreg;
  logic              par_q;
  logic              rxd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      shreg    <= '0;
      par_q    <= 1'b0;
      rxd_q    <= 1'b1;
      ch_valid <= 1'b0;
      ch       <= '0;
    end else begin
      rxd_q    <= rxd;
      ch_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (!rxd_q) begin
            st  <= S_START;
            cnt <= CW'(OVS/2 - 1);
          end
        end
        S_START: begin
          if (cnt == '0) begin
            if (!rxd_q) begin
              st   <= S_DATA;
              cnt  <= CW'(OVS - 1);
              bitn <= '0;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_DATA: begin
          if (cnt == '0) begin
            shreg <= {rxd_q, shreg[CHAR_W-1:1]};
            cnt   <= CW'(OVS - 1);
            if (bitn == BW'(CHAR_W - 1)) st <= S_PAR;
            else bitn <= bitn + 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_PAR: begin
          if (cnt == '0) begin
            par_q <= rxd_q;
            cnt   <= CW'(OVS - 1);
            st    <= S_STOP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_STOP: begin
          if (cnt == '0) begin
            ch_valid <= 1'b1;
            ch.data  <= shreg;
            ch.pe    <= ^{shreg, par_q};
            ch.fe    <= ~rxd_q;
            st       <= rxd_q ? S_IDLE : S_RESYNC;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_RESYNC: begin
          // Second look at the low stop level, now taken as a start bit.
          if (!rxd_q) begin
            st   <= S_DATA;
            cnt  <= CW'(OVS - 2);
            bitn <= '0;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_ls_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr,
  input  rx_char_t                 wdata,
  input  logic                     pop,
  output rx_char_t                 head,
  output logic                     pop_ok,
  output logic                     wr_ok,
  output logic                     ovr,
  output logic                     dr_n,
  output logic                     head_arrive,
  output logic [$clog2(DEPTH):0]   fill
);
  localparam int unsigned AW = $clog2(DEPTH);

  rx_char_t        mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [AW:0]     fill_n;
  logic            full, empty, head_chg;

  assign full   = (fill == (AW+1)'(DEPTH));
  assign empty  = (fill == '0);
  assign pop_ok = pop & ~empty;
  assign wr_ok  = wr & (~full | pop_ok);
  assign ovr    = wr & full & ~pop_ok;
  assign fill_n = fill + (AW+1)'(wr_ok) - (AW+1)'(pop_ok);
  assign dr_n   = (fill_n != '0);
  assign head_chg = (pop_ok & (fill_n != '0)) | (wr_ok & empty);
  assign head   = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp          <= '0;
      rp          <= '0;
      fill        <= '0;
      head_arrive <= 1'b0;
    end else begin
      if (wr_ok)  wp <= wp + 1'b1;
      if (pop_ok) rp <= rp + 1'b1;
      fill        <= fill_n;
      head_arrive <= head_chg;
    end
  end
endmodule

// File: rtl/uart_rx_lsr_flags.sv
module uart_rx_lsr_flags
  import uart_rx_ls_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ovr_evt,
  input  logic              head_arrive,
  input  logic              head_pe,
  input  logic              head_fe,
  input  logic              lsr_rd,
  input  logic              dr_n,
  output logic [STAT_W-1:0] stat,
  output logic              irq
);
  logic oe_n, pe_n, fe_n;

  // Set events take priority over the read-to-clear.
  assign oe_n = ovr_evt | (stat[ST_OE] & ~lsr_rd);
  assign pe_n = (head_arrive & head_pe) | (stat[ST_PE] & ~lsr_rd);
  assign fe_n = (head_arrive & head_fe) | (stat[ST_FE] & ~lsr_rd);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      irq  <= 1'b0;
    end else begin
      stat[ST_DR] <= dr_n;
      stat[ST_OE] <= oe_n;
      stat[ST_PE] <= pe_n;
      stat[ST_FE] <= fe_n;
      irq         <= oe_n | pe_n | fe_n;
    end
  end
endmodule

// File: rtl/uart_rx_line_status.sv
module uart_rx_line_status
  import uart_rx_ls_pkg::*;
#(
  parameter int unsigned OVS   = 16,
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd,
  input  logic              rd_en,
  input  logic              lsr_rd,
  output logic [CHAR_W-1:0] rd_data,
  output logic [STAT_W-1:0] line_stat,
  output logic              ls_irq
);
  logic     ch_valid;
  rx_char_t ch, head;
  logic     pop_ok, ovr_evt, dr_n, head_arrive;

  uart_rx_sampler #(.OVS(OVS)) u_samp (
    .clk(clk), .rst(rst), .rxd(rxd), .ch_valid(ch_valid), .ch(ch)
  );

  uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr(ch_valid), .wdata(ch), .pop(rd_en),
    .head(head), .pop_ok(pop_ok), .wr_ok(), .ovr(ovr_evt), .dr_n(dr_n),
    .head_arrive(head_arrive), .fill()
  );

  uart_rx_lsr_flags u_flags (
    .clk(clk), .rst(rst), .ovr_evt(ovr_evt), .head_arrive(head_arrive),
    .head_pe(head.pe), .head_fe(head.fe), .lsr_rd(lsr_rd), .dr_n(dr_n),
    .stat(line_stat), .irq(ls_irq)
  );

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (pop_ok) rd_data <= head.data;
  end
endmodule

// File: rtl/uart_rx_line_status_chk.sv
module uart_rx_line_status_chk #(
  parameter int unsigned DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic [3:0]             stat,
  input logic                   irq,
  input logic                   lsr_rd,
  input logic                   char_wr,
  input logic                   ovr_evt,
  input logic                   head_arrive,
  input logic [$clog2(DEPTH):0] fill
);
  a_r3_dr_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[0]) |-> $past(char_wr));
  a_r5_oe_set: assert property (@(posedge clk) disable iff (rst)
    ovr_evt |=> stat[1]);
  a_r5_fill_kept: assert property (@(posedge clk) disable iff (rst)
    ovr_evt |=> fill == $past(fill));
  a_r5_fill_bound: assert property (@(posedge clk) disable iff (rst)
    fill <= ($clog2(DEPTH)+1)'(DEPTH));
  a_r7_oe_sticky: assert property (@(posedge clk) disable iff (rst)
    (stat[1] && !lsr_rd) |=> stat[1]);
  a_r7_pe_sticky: assert property (@(posedge clk) disable iff (rst)
    (stat[2] && !lsr_rd) |=> stat[2]);
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !ovr_evt && !head_arrive) |=> stat[3:1] == 3'b000);
  a_r10_irq: assert property (@(posedge clk) disable iff (rst)
    irq == (|stat[3:1]));
endmodule

bind uart_rx_line_status uart_rx_line_status_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .stat(line_stat), .irq(ls_irq), .lsr_rd(lsr_rd),
  .char_wr(u_fifo.wr_ok), .ovr_evt(ovr_evt), .head_arrive(head_arrive),
  .fill(u_fifo.fill)
);

// File: tb/sim_uart_rx_line_status.sv
module sim_uart_rx_line_status;
  localparam int OVS   = 4;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic       rd_en = 1'b0;
  logic       lsr_rd = 1'b0;
  logic [7:0] rd_data;
  logic [3:0] line_stat;
  logic       ls_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_rx_line_status #(.OVS(OVS), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .rxd(rxd), .rd_en(rd_en), .lsr_rd(lsr_rd),
    .rd_data(rd_data), .line_stat(line_stat), .ls_irq(ls_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    rxd = b;
    repeat (OVS) @(negedge clk);
  endtask

  task automatic send_tail(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit((^d) ^ bad_par);
    send_bit(~bad_stop);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    send_bit(1'b0);
    send_tail(d, bad_par, bad_stop);
  endtask

  task automatic read_stat(output logic [3:0] v);
    v = line_stat;
    lsr_rd = 1'b1;
    @(negedge clk);
    lsr_rd = 1'b0;
  endtask

  task automatic pop(output logic [7:0] d);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [3:0] v;
    logic [7:0] d;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk(line_stat == 4'h0, "R1 stat", line_stat, 0);
    chk(ls_irq == 1'b0, "R1 irq", ls_irq, 0);
    chk(rd_data == 8'h00, "R1 data", rd_data, 0);

    // R4 read while empty has no effect
    pop(d);
    chk(d == 8'h00, "R4 empty read data", d, 0);
    chk(line_stat[0] == 1'b0, "R4 empty read dr", line_stat[0], 0);

    // R2 R3 R6 R10 sweep over every byte value
    for (int k = 0; k < 256; k++) begin
      bit pe_exp;
      pe_exp = (k % 3 == 0);
      send_frame(8'(k), pe_exp, 1'b0);
      tick(4);
      chk(line_stat == {1'b0, pe_exp, 1'b0, 1'b1}, "R2 R3 R6 sweep stat",
          line_stat, {1'b0, pe_exp, 1'b0, 1'b1});
      chk(ls_irq == pe_exp, "R10 sweep irq", ls_irq, pe_exp);
      read_stat(v);
      pop(d);
      chk(d == 8'(k), "R2 sweep data", d, k);
      tick(2);
      chk(line_stat == 4'h0, "R3 R7 sweep cleared", line_stat, 0);
    end

    // R6 error shown only at head
    send_frame(8'h11, 1'b0, 1'b0);
    send_frame(8'h22, 1'b1, 1'b0);
    tick(4);
    chk(line_stat == 4'b0001, "R6 tagged char behind head", line_stat, 4'b0001);
    pop(d);
    chk(d == 8'h11, "R4 order first", d, 8'h11);
    chk(line_stat[2] == 1'b0, "R6 latch not yet", line_stat[2], 0);
    tick(1);
    chk(line_stat == 4'b0101, "R6 pe at head", line_stat, 4'b0101);
    chk(ls_irq == 1'b1, "R10 irq pe", ls_irq, 1);
    // R7 sticky while not read
    tick(10);
    chk(line_stat == 4'b0101, "R7 sticky", line_stat, 4'b0101);
    read_stat(v);
    chk(v == 4'b0101, "R7 read value", v, 4'b0101);
    chk(line_stat == 4'b0001, "R7 cleared by read", line_stat, 4'b0001);
    chk(ls_irq == 1'b0, "R10 irq cleared", ls_irq, 0);
    pop(d);
    chk(d == 8'h22, "R4 order second", d, 8'h22);
    tick(2);

    // R8 R9 same-cycle read and pop; low stop then idle line
    send_frame(8'h3C, 1'b1, 1'b0);
    send_frame(8'h81, 1'b0, 1'b1);
    rxd = 1'b1;
    tick(OVS * 11 + 4);
    chk(line_stat == 4'b0101, "R8 before", line_stat, 4'b0101);
    v = line_stat;
    lsr_rd = 1'b1;
    rd_en = 1'b1;
    @(negedge clk);
    lsr_rd = 1'b0;
    rd_en = 1'b0;
    chk(v == 4'b0101, "R8 old head flags", v, 4'b0101);
    chk(rd_data == 8'h3C, "R8 popped data", rd_data, 8'h3C);
    chk(line_stat == 4'b0001, "R8 cleared", line_stat, 4'b0001);
    tick(1);
    chk(line_stat == 4'b1001, "R8 R9 new head fe", line_stat, 4'b1001);
    read_stat(v);
    pop(d);
    chk(d == 8'h81, "R9 fe char data", d, 8'h81);
    tick(1);
    chk(line_stat == 4'b0101, "R9 resync char pe", line_stat, 4'b0101);
    read_stat(v);
    pop(d);
    chk(d == 8'hFF, "R9 resync on idle line", d, 8'hFF);
    tick(2);
    chk(line_stat == 4'h0, "R3 empty after", line_stat, 0);

    // R9 low stop followed directly by next character
    send_frame(8'h5A, 1'b0, 1'b1);
    send_tail(8'hC3, 1'b0, 1'b0);
    tick(4);
    chk(line_stat == 4'b1001, "R9 fe at head", line_stat, 4'b1001);
    read_stat(v);
    pop(d);
    chk(d == 8'h5A, "R9 first char", d, 8'h5A);
    tick(2);
    chk(line_stat == 4'b0001, "R9 second clean", line_stat, 4'b0001);
    pop(d);
    chk(d == 8'hC3, "R9 resynced char", d, 8'hC3);
    tick(2);
    chk(line_stat == 4'h0, "R9 empty", line_stat, 0);

    // R5 overrun
    for (int i = 0; i < DEPTH; i++) send_frame(8'(8'h10 + i), 1'b0, 1'b0);
    tick(4);
    chk(line_stat == 4'b0001, "R5 full no overrun", line_stat, 4'b0001);
    send_frame(8'h99, 1'b0, 1'b0);
    tick(4);
    chk(line_stat == 4'b0011, "R5 overrun set", line_stat, 4'b0011);
    chk(ls_irq == 1'b1, "R10 irq oe", ls_irq, 1);
    for (int i = 0; i < DEPTH; i++) begin
      pop(d);
      chk(d == 8'(8'h10 + i), "R5 contents intact", d, 8'h10 + i);
    end
    tick(2);
    chk(line_stat == 4'b0010, "R3 R5 empty oe held", line_stat, 4'b0010);
    pop(d);
    chk(d == 8'h13, "R4 extra read ignored", d, 8'h13);
    read_stat(v);
    chk(line_stat == 4'h0, "R7 oe cleared", line_stat, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule